// File: doc/BRIEF.md
# Configuration Header Clock Ratio Selector

This block sits beside the data path that streams a configuration image, one 32-bit word per beat, into a parallel configuration port. It does not change the words. As they pass, it counts them from the start of the image. It takes the encryption field from one fixed header word and the compression flag from a later fixed header word. It then combines the two with the selected port width and gives the clock-to-data ratio code that the port clock divider must use.

The code comes with a valid flag. Both stay steady until the next image start. If the image ends before the second header word arrives, the block raises a sticky error flag instead. Words are never refused, so the stream is never stalled.

Top module: `hdr_ratio_sel`

## Requirements
- R1: `wordReady` is high in every cycle, including during reset, so every beat with `wordValid` high is accepted.
- R2: After reset, `ratioValid` is 0, `ratioCode` is 0 and `hdrError` is 0, and word counting starts at index 0.
- R3: Accepted words are numbered from 0. A word accepted in the same cycle as `imgStart` is word 0 of the new image.
- R4: The image counts as encrypted when bits [3:2] of word 69 hold any nonzero value. The same bits in every other word have no effect.
- R5: The image counts as compressed when bit 1 of word 229 is 0. That bit in every other word has no effect.
- R6: The ratio code is 0 (x1) when the image is neither encrypted nor compressed, whatever the width. Otherwise the base code is 2 (x4) when compressed, or 1 (x2) when only encrypted. The base code is raised by one when `wideSel` is 1 (32-bit port); `wideSel` is 0 for a 16-bit port. `wideSel` is sampled with word 229. The codes mean 0=x1, 1=x2, 2=x4, 3=x8.
- R7: `ratioValid` and `ratioCode` take their values on the clock edge after word 229 is accepted. They then hold unchanged until `imgStart`, whatever words or `wideSel` values follow.
- R8: An accepted word with `wordLast` high and index below 229 sets `hdrError` on the next edge. `hdrError` holds until `imgStart`, and later words are ignored. `wordLast` on word 229 itself is not an error.
- R9: `imgStart` clears `ratioValid`, `ratioCode` and `hdrError` on the next edge, unless that same cycle holds a word-0 end that R8 flags.
- R10: Cycles with `wordValid` low do not advance the word index.
- R11: `ratioValid` and `hdrError` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| imgStart | input | 1 | Pulse marking the start of a new image |
| wordValid | input | 1 | Beat carries an image word |
| wordData | input | 32 | Image word |
| wordLast | input | 1 | Beat is the last word of the image |
| wideSel | input | 1 | Port width: 1 = 32-bit, 0 = 16-bit |
| wordReady | output | 1 | Always high: words are always accepted |
| ratioCode | output | 2 | Clock-to-data ratio code (0=x1, 1=x2, 2=x4, 3=x8) |
| ratioValid | output | 1 | Ratio code is decided for the current image |
| hdrError | output | 1 | Image ended before the header was complete |

## Verification
The hardest case to reach from the ports is an off-by-one in word indexing. A counter that is one word early or late would still give a plausible code. To expose it, the stimulus fills every word other than 69 and 229 with a pattern that looks both encrypted and compressed. A wrong index then moves the code away from the expected value. Idle gaps of several spacings are mixed into the stream so that stalls test the counter too. An image cut short at word 228 is set against one that ends exactly at word 229; this exercises the error boundary.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

  typedef struct packed {
    logic clear;
    logic capEnc;
    logic capCmp;
    logic fail;
  } hdrStrobe_t;

  localparam logic [1:0] RATIO_X1 = 2'd0;
  localparam logic [1:0] RATIO_X2 = 2'd1;
  localparam logic [1:0] RATIO_X4 = 2'd2;

endpackage

// File: rtl/hdr_ratio_ctrl.sv
module hdr_ratio_ctrl
  import hdr_ratio_pkg::*;
#(
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       imgStart,
  input  logic       wordValid,
  input  logic       wordLast,
  output hdrStrobe_t strobe
);
  localparam int CNT_W = $clog2(CMP_IDX + 2);
  localparam logic [CNT_W-1:0] ENC_AT = CNT_W'(ENC_IDX);
  localparam logic [CNT_W-1:0] CMP_AT = CNT_W'(CMP_IDX);

  logic [CNT_W-1:0] wordCnt;
  logic [CNT_W-1:0] curIdx;
  logic             locked;
  logic             accept;

  always_comb begin
    curIdx = imgStart ? '0 : wordCnt;
    accept = wordValid && (imgStart || !locked);
    strobe.clear  = imgStart;
    strobe.capEnc = accept && (curIdx == ENC_AT);
    strobe.capCmp = accept && (curIdx == CMP_AT);
    strobe.fail   = accept && wordLast && (curIdx < CMP_AT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCnt <= '0;
      locked  <= 1'b0;
    end else begin
      if (accept) wordCnt <= curIdx + 1'b1;
      else if (imgStart) wordCnt <= '0;
      if (imgStart) locked <= strobe.capCmp || strobe.fail;
      else if (strobe.capCmp || strobe.fail) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/hdr_ratio_dp.sv
module hdr_ratio_dp
  import hdr_ratio_pkg::*;
#(
  parameter int ENC_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  hdrStrobe_t       strobe,
  input  logic [ENC_W-1:0] encField,
  input  logic             cmpBit,
  input  logic             wideSel,
  output logic [1:0]       ratioCode,
  output logic             ratioValid,
  output logic             hdrError
);
  logic       encSeen;
  logic       isCmp;
  logic [1:0] nextCode;

  always_comb begin
    isCmp = !cmpBit;
    if (!isCmp && !encSeen) nextCode = RATIO_X1;
    else nextCode = (isCmp ? RATIO_X4 : RATIO_X2) + {1'b0, wideSel};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encSeen    <= 1'b0;
      ratioCode  <= RATIO_X1;
      ratioValid <= 1'b0;
      hdrError   <= 1'b0;
    end else begin
      if (strobe.capEnc) encSeen <= |encField;
      else if (strobe.clear) encSeen <= 1'b0;
      if (strobe.capCmp) begin
        ratioCode  <= nextCode;
        ratioValid <= 1'b1;
      end else if (strobe.clear) begin
        ratioCode  <= RATIO_X1;
        ratioValid <= 1'b0;
      end
      if (strobe.fail) hdrError <= 1'b1;
      else if (strobe.clear) hdrError <= 1'b0;
    end
  end
endmodule

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel
  import hdr_ratio_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_IDX = 229,
  parameter int CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              imgStart,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] wordData,
  input  logic              wordLast,
  input  logic              wideSel,
  output logic              wordReady,
  output logic [1:0]        ratioCode,
  output logic              ratioValid,
  output logic              hdrError
);
  hdrStrobe_t strobe;
  logic       unusedBits;

  assign wordReady  = 1'b1;
  assign unusedBits = ^wordData;

  hdr_ratio_ctrl #(.ENC_IDX(ENC_IDX), .CMP_IDX(CMP_IDX)) ctrl (
    .clk(clk), .rstN(rstN), .imgStart(imgStart),
    .wordValid(wordValid), .wordLast(wordLast), .strobe(strobe)
  );

  hdr_ratio_dp #(.ENC_W(ENC_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .encField(wordData[ENC_LSB +: ENC_W]), .cmpBit(wordData[CMP_BIT]),
    .wideSel(wideSel), .ratioCode(ratioCode),
    .ratioValid(ratioValid), .hdrError(hdrError)
  );
endmodule

// File: rtl/hdr_ratio_sel_chk.sv
module hdr_ratio_sel_chk (
  input logic       clk,
  input logic       rstN,
  input logic       imgStart,
  input logic       wordValid,
  input logic       wordLast,
  input logic       wideSel,
  input logic       wordReady,
  input logic [1:0] ratioCode,
  input logic       ratioValid,
  input logic       hdrError
);
  always_comb AST_READY_HIGH: assert (wordReady === 1'b1); // R1

  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !(ratioValid && hdrError)); // R11

  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ratioValid && !imgStart |=> ratioValid && $stable(ratioCode)); // R7

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    hdrError && !imgStart |=> hdrError); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    imgStart && !(wordValid && wordLast) |=> !ratioValid && !hdrError && ratioCode == 2'd0); // R9

  AST_RISE_ON_WORD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ratioValid) |-> $past(wordValid)); // R7

  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ratioValid) && !$past(wideSel) |-> ratioCode <= 2'd2); // R6

  AST_WIDE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ratioValid) && $past(wideSel) && ratioCode != 2'd0 |-> ratioCode >= 2'd2); // R6
endmodule

bind hdr_ratio_sel hdr_ratio_sel_chk chk (
  .clk(clk), .rstN(rstN), .imgStart(imgStart), .wordValid(wordValid),
  .wordLast(wordLast), .wideSel(wideSel), .wordReady(wordReady),
  .ratioCode(ratioCode), .ratioValid(ratioValid), .hdrError(hdrError)
);

// File: tb/hdr_ratio_sel_test.sv
module hdr_ratio_sel_test;
  localparam int PERIOD = 10;
  localparam int ENC_AT = 69;
  localparam int CMP_AT = 229;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        imgStart = 1'b0;
  logic        wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic        wordLast = 1'b0;
  logic        wideSel = 1'b0;
  logic        wordReady;
  logic [1:0]  ratioCode;
  logic        ratioValid;
  logic        hdrError;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  hdr_ratio_sel uut (
    .clk(clk), .rstN(rstN), .imgStart(imgStart), .wordValid(wordValid),
    .wordData(wordData), .wordLast(wordLast), .wideSel(wideSel),
    .wordReady(wordReady), .ratioCode(ratioCode),
    .ratioValid(ratioValid), .hdrError(hdrError)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Filler words look both encrypted and compressed, so an index slip shows.
  function automatic logic [31:0] fillWord(input int i);
    return ((32'hC0DE_0000 | 32'(i << 4)) | 32'hC) & ~32'h2;
  endfunction

  function automatic logic [31:0] imgWord(input int i, input int enc, input int cmp);
    logic [31:0] w = fillWord(i);
    if (i == ENC_AT) w = (w & ~32'hC) | 32'(enc << 2);
    if (i == CMP_AT) w = (w & ~32'h2) | 32'(cmp << 1);
    return w;
  endfunction

  function automatic int expCode(input int enc, input int cmp, input int wide);
    if (enc == 0 && cmp == 1) return 0;
    return ((cmp == 0) ? 2 : 1) + wide;
  endfunction

  task automatic pushWord(input logic [31:0] d, input logic last, input logic st);
    wordValid = 1'b1; wordData = d; wordLast = last; imgStart = st;
    @(negedge clk);
    wordValid = 1'b0; wordLast = 1'b0; imgStart = 1'b0;
  endtask

  task automatic runImage(input int enc, input int cmp, input int wide, input int gap);
    int e = expCode(enc, cmp, wide);
    wideSel = wide[0];
    for (int i = 0; i <= CMP_AT; i++) begin
      if (gap > 0 && (i % gap) == gap - 1) @(negedge clk);
      if (i == CMP_AT) chk(!ratioValid, "R7 not early", int'(ratioValid), 0);
      pushWord(imgWord(i, enc, cmp), i == CMP_AT, i == 0);
    end
    chk(ratioValid && !hdrError, "R7/R8 valid after word 229", int'(ratioValid), 1);
    chk(ratioCode == 2'(e), "R6 ratio code (R4 R5 R3 R10)", int'(ratioCode), e);
    wideSel = ~wideSel;
    pushWord(imgWord(CMP_AT, 3, 0), 1'b0, 1'b0);
    pushWord(32'h0, 1'b1, 1'b0);
    chk(ratioValid && ratioCode == 2'(e), "R7 hold", int'(ratioCode), e);
  endtask

  task automatic runShort(input int lastAt);
    wideSel = 1'b1;
    imgStart = 1'b1; @(negedge clk); imgStart = 1'b0;
    chk(!ratioValid && !hdrError && ratioCode == 0, "R9 start clears",
        int'(ratioValid) + int'(hdrError), 0);
    for (int i = 0; i <= lastAt; i++) pushWord(imgWord(i, 1, 0), i == lastAt, 1'b0);
    chk(hdrError && !ratioValid, "R8 error on short image", int'(hdrError), 1);
    for (int i = lastAt + 1; i <= CMP_AT + 1; i++) pushWord(imgWord(i, 1, 0), 1'b0, 1'b0);
    chk(hdrError && !ratioValid, "R8 later words ignored", int'(ratioValid), 0);
  endtask

  initial begin
    #(PERIOD * 2 + 1);
    chk(wordReady, "R1 ready in reset", int'(wordReady), 1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!ratioValid && ratioCode == 0 && !hdrError, "R2 reset state",
        int'(ratioValid) + int'(ratioCode) + int'(hdrError), 0);
    for (int enc = 0; enc < 4; enc++)
      for (int cmp = 0; cmp < 2; cmp++)
        for (int wide = 0; wide < 2; wide++)
          runImage(enc, cmp, wide, (enc * 4 + cmp * 2 + wide) % 5);
    runShort(228);
    runShort(100);
    runShort(0);
    imgStart = 1'b1; @(negedge clk); imgStart = 1'b0;
    chk(!hdrError, "R9 error cleared", int'(hdrError), 0);
    chk(wordReady, "R1 ready", int'(wordReady), 1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule